// File: doc/BRIEF.md
# Side-Panel and Blanking Inserter

This block sits at the end of a video output path and overrides the Y, U and V samples wherever no active picture is present. A delayed copy of the active-low blanking input marks line and field blanking, and forces black there. Outside blanking, an internal read-enable marks where picture memory supplies pixels. Where that read-enable is low, which is the side panels, the block either fills a programmable grey or repeats the last active pixel.

The block also produces two read-enable outputs for the external memories. Each is a copy of its input, delayed by a selectable number of clocks and optionally inverted. The internal read-enable that drives the side-panel decision is the first read-enable input, delayed by a fixed latency `RE_LAT`, default 2, so that it lines up with the arriving samples. All configuration inputs are expected to be static while video flows.

Top module: `spb_top`

## Requirements
- R1: While the delayed blanking signal is low, the outputs one clock later are Y = 0, or Y = 16 when `black16` is 1, with U = V = 0x00.
- R2: The internal blanking signal equals `blank_n_in` delayed by `blank_dly` clocks (code 0 to 3 gives 0 to 3 clocks).
- R3: Blanking wins over pass-through, grey fill and pixel repetition, whatever the read-enable and `pix_rep` are.
- R4: Outside blanking with the internal read-enable high, the outputs one clock later equal the input Y/U/V samples.
- R5: The internal read-enable is `re_a_in` delayed by `RE_LAT` clocks.
- R6: Outside blanking with the internal read-enable low and `pix_rep` = 0, the outputs one clock later are Y = `grey_msb` in bits 7:4 with bits 3:0 zero, and U = V = 0x00.
- R7: Outside blanking with the internal read-enable low and `pix_rep` = 1, the outputs repeat the last sample that passed through under R4. Samples arriving during blanking or side panels never update the repeated value; after reset the repeated value is all zero.
- R8: Each read-enable output is its input delayed by 5 + code clocks, where the 2-bit code (`re_a_dly`, `re_b_dly`) gives 5, 6, 7 or 8.
- R9: Each read-enable output is inverted when its own inversion bit is 1, independently of the other output.
- R10: While `rst` is high, Y, U and V read 0 and each read-enable output equals its inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| blank_n_in | input | 1 | blanking input, low during blanking |
| re_a_in | input | 1 | read-enable of the first memory; also the side-panel marker |
| re_b_in | input | 1 | read-enable of the second memory |
| y_in | input | 8 | luminance sample |
| u_in | input | 8 | U sample, two's complement |
| v_in | input | 8 | V sample, two's complement |
| blank_dly | input | 2 | blanking delay code, 0 to 3 clocks |
| re_a_dly | input | 2 | delay code of the first read-enable output |
| re_b_dly | input | 2 | delay code of the second read-enable output |
| re_a_inv | input | 1 | invert the first read-enable output |
| re_b_inv | input | 1 | invert the second read-enable output |
| black16 | input | 1 | blank luminance level 16 instead of 0 |
| pix_rep | input | 1 | repeat the last pixel in side panels instead of grey |
| grey_msb | input | 4 | upper four bits of the side-panel grey |
| y_out | output | 8 | processed luminance |
| u_out | output | 8 | processed U |
| v_out | output | 8 | processed V |
| re_a_out | output | 1 | delayed first read-enable |
| re_b_out | output | 1 | delayed second read-enable |

## Verification
The assertions assume that the configuration inputs hold still, because the fill checks compare against the value one clock back. The read-enable and blanking delay checks also need at least eight clocks since reset, so that the shift history contains no values captured during reset. The bench keeps to this by holding each configuration fixed from a reset to the next. It sweeps all delay codes, both inversion bits, both black levels, both side-panel modes and a range of grey values. The blanking and read-enable patterns have runs long enough to contain consecutive hold cycles and edges at every offset.

// File: rtl/spb_pkg.sv
package spb_pkg;

    parameter int PIX_W  = 8;
    localparam int GREY_W = 4;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] u;
        logic [PIX_W-1:0] v;
    } pix_t;

    typedef enum logic [1:0] {
        FILL_BLANK  = 2'd0,
        FILL_ACTIVE = 2'd1,
        FILL_GREY   = 2'd2,
        FILL_HOLD   = 2'd3
    } fill_e;

    typedef struct packed {
        logic              black16;
        logic              pix_rep;
        logic [GREY_W-1:0] grey_msb;
    } fill_cfg_t;

    // Blanking first, then live video, then the side-panel mode.
    function automatic fill_e pick_fill(input logic blank_n, input logic re_act,
                                        input logic rep);
        if (!blank_n)    return FILL_BLANK;
        else if (re_act) return FILL_ACTIVE;
        else if (rep)    return FILL_HOLD;
        else             return FILL_GREY;
    endfunction

    function automatic pix_t black_pix(input logic b16);
        pix_t p;
        p.y = b16 ? PIX_W'(16) : '0;
        p.u = '0;
        p.v = '0;
        return p;
    endfunction

    function automatic pix_t grey_pix(input logic [GREY_W-1:0] g);
        pix_t p;
        p.y = {g, {(PIX_W-GREY_W){1'b0}}};
        p.u = '0;
        p.v = '0;
        return p;
    endfunction

endpackage

// File: rtl/spb_tap_delay.sv
module spb_tap_delay #(
    parameter int MIN_DLY = 0,
    parameter int SEL_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d,
    input  logic [SEL_W-1:0] sel,
    output logic             q
);
    localparam int DEPTH = MIN_DLY + (1 << SEL_W) - 1;
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] sr;
    logic [IW-1:0]    idx;
    int               tot;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) sr[0] <= 1'b0;
                else     sr[0] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) sr[k] <= 1'b0;
                else     sr[k] <= sr[k-1];
            end
        end
    end

    always_comb begin
        tot = MIN_DLY + int'(sel);
        idx = IW'(tot - 1);
    end

    if (MIN_DLY == 0) begin : g_bypass
        always_comb q = (sel == '0) ? d : sr[idx];
    end else begin : g_fixed
        always_comb q = sr[idx];
    end

endmodule

// File: rtl/spb_re_port.sv
module spb_re_port #(
    parameter int MIN_DLY = 5,
    parameter int SEL_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             re_in,
    input  logic [SEL_W-1:0] dly_sel,
    input  logic             inv,
    output logic             re_out
);
    localparam int MAX_DLY = MIN_DLY + (1 << SEL_W) - 1;

    logic re_dly;
    logic [3:0] age;

    spb_tap_delay #(.MIN_DLY(MIN_DLY), .SEL_W(SEL_W)) u_tap (
        .clk (clk),
        .rst (rst),
        .d   (re_in),
        .sel (dly_sel),
        .q   (re_dly)
    );

    assign re_out = re_dly ^ inv;

    always_ff @(posedge clk) begin
        if (rst)               age <= '0;
        else if (age != 4'hF)  age <= age + 4'd1;
    end

    if (MIN_DLY == 5 && SEL_W == 2) begin : g_chk
        // R8 R9
        re_short_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 4'd8 && dly_sel == 2'd0) |-> (re_out == ($past(re_in, 5) ^ inv)));
        // R8 R9
        re_long_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 4'd8 && dly_sel == 2'd3) |-> (re_out == ($past(re_in, 8) ^ inv)));
    end

endmodule

// File: rtl/spb_fill.sv
module spb_fill
    import spb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      blank_n,
    input  logic      re_act,
    input  pix_t      pix_in,
    input  fill_cfg_t cfg,
    output pix_t      pix_out
);
    fill_e sel;
    pix_t  hold_q;
    pix_t  out_q;
    pix_t  nxt;

    always_comb begin
        sel = pick_fill(blank_n, re_act, cfg.pix_rep);
        unique case (sel)
            FILL_BLANK:  nxt = black_pix(cfg.black16);
            FILL_ACTIVE: nxt = pix_in;
            FILL_HOLD:   nxt = hold_q;
            default:     nxt = grey_pix(cfg.grey_msb);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            hold_q <= '0;
        end else begin
            out_q <= nxt;
            if (sel == FILL_ACTIVE) hold_q <= pix_in;
        end
    end

    assign pix_out = out_q;

    // R1 R3
    blank_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |=> (pix_out.y == ($past(cfg.black16) ? PIX_W'(16) : '0))
                     && (pix_out.u == '0) && (pix_out.v == '0));
    // R4
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_n && re_act) |=> (pix_out == $past(pix_in)));
    // R6
    grey_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_n && !re_act && !cfg.pix_rep) |=>
            (pix_out.y[PIX_W-1 -: GREY_W] == $past(cfg.grey_msb))
            && (pix_out.y[PIX_W-GREY_W-1:0] == '0)
            && (pix_out.u == '0) && (pix_out.v == '0));
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_n && !re_act && cfg.pix_rep) ##1 (blank_n && !re_act && cfg.pix_rep)
            |=> $stable(pix_out));

endmodule

// File: rtl/spb_top.sv
module spb_top
    import spb_pkg::*;
#(
    parameter int RE_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blank_n_in,
    input  logic             re_a_in,
    input  logic             re_b_in,
    input  logic [PIX_W-1:0] y_in,
    input  logic [PIX_W-1:0] u_in,
    input  logic [PIX_W-1:0] v_in,
    input  logic [1:0]       blank_dly,
    input  logic [1:0]       re_a_dly,
    input  logic [1:0]       re_b_dly,
    input  logic             re_a_inv,
    input  logic             re_b_inv,
    input  logic             black16,
    input  logic             pix_rep,
    input  logic [3:0]       grey_msb,
    output logic [PIX_W-1:0] y_out,
    output logic [PIX_W-1:0] u_out,
    output logic [PIX_W-1:0] v_out,
    output logic             re_a_out,
    output logic             re_b_out
);
    localparam int N_RE = 2;

    logic       blank_i;
    logic       re_int;
    pix_t       pix_in;
    pix_t       pix_out;
    fill_cfg_t  cfg;
    logic [3:0] warm;

    logic [N_RE-1:0]      re_in_v;
    logic [N_RE-1:0]      re_inv_v;
    logic [N_RE-1:0][1:0] re_dly_v;
    logic [N_RE-1:0]      re_out_v;

    // Blanking delay, 0 to 3 clocks.
    spb_tap_delay #(.MIN_DLY(0), .SEL_W(2)) u_blank_dly (
        .clk (clk),
        .rst (rst),
        .d   (blank_n_in),
        .sel (blank_dly),
        .q   (blank_i)
    );

    // Fixed latency match for the side-panel marker.
    spb_tap_delay #(.MIN_DLY(RE_LAT), .SEL_W(1)) u_re_match (
        .clk (clk),
        .rst (rst),
        .d   (re_a_in),
        .sel (1'b0),
        .q   (re_int)
    );

    assign re_in_v  = {re_b_in, re_a_in};
    assign re_inv_v = {re_b_inv, re_a_inv};
    assign re_dly_v = {re_b_dly, re_a_dly};

    for (genvar i = 0; i < N_RE; i++) begin : g_re
        spb_re_port #(.MIN_DLY(5), .SEL_W(2)) u_port (
            .clk     (clk),
            .rst     (rst),
            .re_in   (re_in_v[i]),
            .dly_sel (re_dly_v[i]),
            .inv     (re_inv_v[i]),
            .re_out  (re_out_v[i])
        );
    end

    assign re_a_out = re_out_v[0];
    assign re_b_out = re_out_v[1];

    assign pix_in = '{y: y_in, u: u_in, v: v_in};
    assign cfg    = '{black16: black16, pix_rep: pix_rep, grey_msb: grey_msb};

    spb_fill u_fill (
        .clk     (clk),
        .rst     (rst),
        .blank_n (blank_i),
        .re_act  (re_int),
        .pix_in  (pix_in),
        .cfg     (cfg),
        .pix_out (pix_out)
    );

    assign y_out = pix_out.y;
    assign u_out = pix_out.u;
    assign v_out = pix_out.v;

    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 4'hF) warm <= warm + 4'd1;
    end

    // R2
    blank_dly3_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 4'd4 && blank_dly == 2'd3) |-> (blank_i == $past(blank_n_in, 3)));
    // R2
    blank_dly1_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 4'd4 && blank_dly == 2'd1) |-> (blank_i == $past(blank_n_in)));

endmodule

// File: tb/tb_spb_top.sv
module tb_spb_top;
    localparam int RE_LAT = 2;
    localparam int NSTEP  = 60;
    localparam int NCFG   = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic blank_n_in = 1'b0, re_a_in = 1'b0, re_b_in = 1'b0;
    logic [7:0] y_in = '0, u_in = '0, v_in = '0;
    logic [1:0] blank_dly = '0, re_a_dly = '0, re_b_dly = '0;
    logic re_a_inv = 1'b0, re_b_inv = 1'b0, black16 = 1'b0, pix_rep = 1'b0;
    logic [3:0] grey_msb = '0;
    logic [7:0] y_out, u_out, v_out;
    logic re_a_out, re_b_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    bit         h_bn [NSTEP];
    bit         h_ra [NSTEP];
    bit         h_rb [NSTEP];
    logic [7:0] h_y  [NSTEP];
    logic [7:0] h_u  [NSTEP];
    logic [7:0] h_v  [NSTEP];

    always #2.5 clk = ~clk;

    spb_top #(.RE_LAT(RE_LAT)) dut (
        .clk(clk), .rst(rst), .blank_n_in(blank_n_in), .re_a_in(re_a_in),
        .re_b_in(re_b_in), .y_in(y_in), .u_in(u_in), .v_in(v_in),
        .blank_dly(blank_dly), .re_a_dly(re_a_dly), .re_b_dly(re_b_dly),
        .re_a_inv(re_a_inv), .re_b_inv(re_b_inv), .black16(black16),
        .pix_rep(pix_rep), .grey_msb(grey_msb), .y_out(y_out), .u_out(u_out),
        .v_out(v_out), .re_a_out(re_a_out), .re_b_out(re_b_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit hist(input bit arr [NSTEP], input int idx);
        return (idx >= 0) ? arr[idx] : 1'b0;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    initial begin
        for (int c = 0; c < NCFG; c++) begin
            logic [7:0] hy, hu, hv;
            logic [7:0] ey, eu, ev;
            string tag;
            bit bi, ri;
            int ia, ib;
            // configuration held static from reset onward
            @(negedge clk);
            rst = 1'b1;
            blank_n_in = 1'b0; re_a_in = 1'b0; re_b_in = 1'b0;
            y_in = '0; u_in = '0; v_in = '0;
            blank_dly = c[1:0];
            re_a_dly  = c[3:2];
            re_b_dly  = ~c[3:2];
            re_a_inv  = c[4];
            re_b_inv  = ~c[4] ^ c[0];
            black16   = c[5];
            pix_rep   = ^c[5:0];
            grey_msb  = 4'(c * 3 + 1);
            @(negedge clk);
            @(negedge clk);
            // R10: reset state
            chk("R10 y", int'(y_out), 0);
            chk("R10 u", int'(u_out), 0);
            chk("R10 v", int'(v_out), 0);
            chk("R10 re_a", int'(re_a_out), int'(re_a_inv));
            chk("R10 re_b", int'(re_b_out), int'(re_b_inv));
            rst = 1'b0;
            hy = '0; hu = '0; hv = '0;
            for (int n = 0; n < NSTEP; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                h_bn[n] = ((n + c) % 17) < 13;
                h_ra[n] = ((n + 2 * c) % 11) < 6;
                h_rb[n] = lfsr[3];
                h_y[n]  = lfsr[7:0];
                h_u[n]  = lfsr[15:8];
                h_v[n]  = lfsr[7:0] ^ lfsr[15:8] ^ 8'h5A;
                blank_n_in = h_bn[n];
                re_a_in    = h_ra[n];
                re_b_in    = h_rb[n];
                y_in = h_y[n]; u_in = h_u[n]; v_in = h_v[n];

                bi = hist(h_bn, n - int'(blank_dly));
                ri = hist(h_ra, n - RE_LAT);
                if (!bi) begin
                    ey = black16 ? 8'd16 : 8'd0; eu = '0; ev = '0;
                    tag = ri ? "R1 R2 R3 blank-over-active" : "R1 R2 R3 blank";
                end else if (ri) begin
                    ey = h_y[n]; eu = h_u[n]; ev = h_v[n];
                    tag = "R4 R5 active";
                end else if (pix_rep) begin
                    ey = hy; eu = hu; ev = hv;
                    tag = "R7 hold";
                end else begin
                    ey = {grey_msb, 4'b0000}; eu = '0; ev = '0;
                    tag = "R6 grey";
                end
                if (bi && ri) begin
                    hy = h_y[n]; hu = h_u[n]; hv = h_v[n];
                end

                @(negedge clk);
                chk({tag, " y"}, int'(y_out), int'(ey));
                chk({tag, " u"}, int'(u_out), int'(eu));
                chk({tag, " v"}, int'(v_out), int'(ev));
                ia = n + 1 - 5 - int'(re_a_dly);
                ib = n + 1 - 5 - int'(re_b_dly);
                chk("R8 R9 re_a", int'(re_a_out), int'(hist(h_ra, ia) ^ re_a_inv));
                chk("R8 R9 re_b", int'(re_b_out), int'(hist(h_rb, ib) ^ re_b_inv));
            end
        end
        done = 1'b1;
        report();
    end

endmodule